// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block is the bus-facing half of a small serial configuration memory. It watches sampled copies of the two I2C lines, recognises bus Start and Stop conditions, and decodes the first byte of each transfer as a device select. That byte carries a fixed memory type code, three strap bits that must match the `chip_en_i` pins, and a direction bit. When the select matches, the slave acknowledges by pulling SDA low through `sda_oe_o` (open drain: a 1 means the line is held low). It then runs one of five transfers on its internal 256 x 8 array: byte write, page write, random read, current-address read or sequential read.

Writes are collected in a 16-byte page buffer and reach the array only when the master ends the transfer with Stop. The Stop also starts a self-timed write cycle of `WR_CYCLES` clocks. For that whole interval the slave takes no notice of the bus at all, so a master finds the end of the cycle by sending selects until one is acknowledged. Write protection is decided outside the block: the slave shows the address of the byte it is about to accept on `wp_addr_o` and reads the verdict on `wr_ok_i`.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the slave does not drive SDA (`sda_oe_o` = 0) and `busy_o` is 0.
- R2: A select byte (sent MSB first) is acknowledged only when its upper nibble is 1010 and its bits 3..1 equal `chip_en_i[2:0]`. Bit 0 is 1 for a read and 0 for a write. Any other select gets NoAck, and the slave then ignores the bus until the next Start.
- R3: A write select, a word address byte and one data byte, all acknowledged and followed by Stop, store the byte at that address. A later random read (write select, address, repeated Start, read select) returns it.
- R4: In a page write, the low 4 address bits advance after each accepted byte and wrap within the 16-byte page, while bits 7..4 stay fixed. A later byte to the same location replaces the earlier one, and locations outside the page are untouched.
- R5: A sequential read returns successive bytes. After each byte sent, the address advances across the full 8 bits, wrapping from FFh to 00h.
- R6: A current-address read (read select with no address phase) returns the byte one past the location last read or written.
- R7: Pending write data reach the array only at a Stop. A repeated Start discards them, and no write cycle starts.
- R8: A Stop after accepted write data keeps `busy_o` high for exactly `WR_CYCLES` clocks. During that time no select is acknowledged and SDA is never driven.
- R9: When `wr_ok_i` is 0 for the address shown on `wp_addr_o`, the data byte gets NoAck, all pending data are dropped, and the following Stop starts no write cycle.
- R10: After the master answers a read byte with NoAck, the slave releases SDA and drives nothing more until the next Start.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus value) |
| chip_en_i | input | 3 | Strap value the select bits 3..1 must match |
| wr_ok_i | input | 1 | 1 when the address on `wp_addr_o` may be written |
| wp_addr_o | output | ADDR_W | Address the next incoming data byte would target |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| busy_o | output | 1 | High during the self-timed internal write cycle |

## Verification
The bench targets the page boundary: 18 bytes written from offset Dh must fold back over the first two locations and leave the next page alone. A design that carries into bit 4 would corrupt the neighbouring page, and one that stops at the page end would lose the overwrite. It reads across FFh to 00h and then does a current-address read. An address counter that saturates, or that only moves on master ACK, returns the wrong byte there. It also interrupts a write with a repeated Start and injects an inhibited address. A slave that commits early, or that acknowledges protected data, shows the wrong data on read-back or raises `busy_o`. Finally it polls during the write cycle and times `busy_o`, which exposes any slave that answers while busy or miscounts the cycle length.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    // Fixed memory type code carried in the upper nibble of the select byte.
    localparam logic [3:0] MEM_TYPE_CODE = 4'b1010;
    localparam int         BYTE_BITS     = 8;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_DEV      = 4'd1,
        ST_DEV_ACK  = 4'd2,
        ST_ADR      = 4'd3,
        ST_ADR_ACK  = 4'd4,
        ST_WDAT     = 4'd5,
        ST_WDAT_ACK = 4'd6,
        ST_TX       = 4'd7,
        ST_TX_ACK   = 4'd8,
        ST_IGNORE   = 4'd9
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_now, sda_now;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh_q <= '1;
                    sda_sh_q <= '1;
                end else begin
                    scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
                    sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh_q <= '1;
                    sda_sh_q <= '1;
                end else begin
                    scl_sh_q <= scl_i;
                    sda_sh_q <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_now = scl_sh_q[STAGES-1];
    assign sda_now = sda_sh_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_now;
            sda_prev_q <= sda_now;
        end
    end

    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_prev_q;
    assign scl_fall  = ~scl_now & scl_prev_q;
    assign start_det = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
    assign stop_det  = scl_now & scl_prev_q & ~sda_prev_q & sda_now;

endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (launch) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [DATA_W-1:0]                  rd_data,
    input  logic                               wr_en,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  wr_data,
    input  logic [PAGE_BYTES-1:0]              wr_mask
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAW   = $clog2(PAGE_BYTES);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (wr_mask[j]) mem_q[{wr_page, PAW'(j)}] <= wr_data[j];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        chip_en_i,
    input  logic              wr_ok_i,
    output logic [ADDR_W-1:0] wp_addr_o,
    output logic              sda_oe_o,
    output logic              busy_o
);

    localparam int PAW  = $clog2(PAGE_BYTES);
    localparam int PG_W = ADDR_W - PAW;
    localparam int BCW  = $clog2(BYTE_BITS + 1);

    typedef struct packed {
        slv_state_t                          st;
        logic [BCW-1:0]                      bits;
        logic [BYTE_BITS-1:0]                sh;
        logic [ADDR_W-1:0]                   ptr;
        logic                                rd_mode;
        logic                                oe;
        logic [PAGE_BYTES-1:0]               mask;
        logic [PAGE_BYTES-1:0][BYTE_BITS-1:0] pbuf;
    } slv_regs_t;

    slv_regs_t q, d;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic busy, launch;
    logic [BYTE_BITS-1:0] rd_data;
    logic in_wr_phase;
    logic [PG_W-1:0] ptr_hi;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy)
    );

    i2c_mem_array #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (BYTE_BITS),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (q.ptr),
        .rd_data (rd_data),
        .wr_en   (launch),
        .wr_page (ptr_hi),
        .wr_data (q.pbuf),
        .wr_mask (q.mask)
    );

    assign ptr_hi = q.ptr[ADDR_W-1:PAW];

    always_comb begin
        d      = q;
        launch = 1'b0;
        if (busy) begin
            // Internal write cycle: the bus is not observed at all.
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.bits = '0;
            d.mask = '0;
        end else if (start_det) begin
            d.st   = ST_DEV;
            d.oe   = 1'b0;
            d.bits = '0;
            d.mask = '0;
        end else if (stop_det) begin
            launch = |q.mask;
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.bits = '0;
            d.mask = '0;
        end else begin
            unique case (q.st)
                ST_DEV, ST_ADR, ST_WDAT: begin
                    if (scl_rise && q.bits != BCW'(BYTE_BITS)) begin
                        d.sh   = {q.sh[BYTE_BITS-2:0], sda_lvl};
                        d.bits = q.bits + BCW'(1);
                    end else if (scl_fall && q.bits == BCW'(BYTE_BITS)) begin
                        d.bits = '0;
                        if (q.st == ST_DEV) begin
                            if (q.sh[7:4] == MEM_TYPE_CODE && q.sh[3:1] == chip_en_i) begin
                                d.oe      = 1'b1;
                                d.rd_mode = q.sh[0];
                                d.st      = ST_DEV_ACK;
                            end else begin
                                d.st = ST_IGNORE;
                            end
                        end else if (q.st == ST_ADR) begin
                            d.ptr = ADDR_W'(q.sh);
                            d.oe  = 1'b1;
                            d.st  = ST_ADR_ACK;
                        end else if (wr_ok_i) begin
                            d.pbuf[q.ptr[PAW-1:0]] = q.sh;
                            d.mask[q.ptr[PAW-1:0]] = 1'b1;
                            d.ptr[PAW-1:0]         = q.ptr[PAW-1:0] + PAW'(1);
                            d.oe                   = 1'b1;
                            d.st                   = ST_WDAT_ACK;
                        end else begin
                            d.mask = '0;
                            d.st   = ST_IGNORE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (q.rd_mode) begin
                            d.sh = rd_data;
                            d.oe = ~rd_data[BYTE_BITS-1];
                            d.st = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_ADR;
                        end
                    end
                end
                ST_ADR_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WDAT;
                    end
                end
                ST_TX: begin
                    if (scl_rise && q.bits != BCW'(BYTE_BITS)) begin
                        d.bits = q.bits + BCW'(1);
                    end else if (scl_fall) begin
                        if (q.bits == BCW'(BYTE_BITS)) begin
                            d.oe   = 1'b0;
                            d.bits = '0;
                            d.ptr  = q.ptr + ADDR_W'(1);
                            d.st   = ST_TX_ACK;
                        end else begin
                            d.sh = {q.sh[BYTE_BITS-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_BITS-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) d.st = ST_IGNORE;
                        else         d.bits = BCW'(1);
                    end else if (scl_fall && q.bits != '0) begin
                        d.bits = '0;
                        d.sh   = rd_data;
                        d.oe   = ~rd_data[BYTE_BITS-1];
                        d.st   = ST_TX;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_wr_phase = (q.st == ST_WDAT) || (q.st == ST_WDAT_ACK);
    assign wp_addr_o   = q.ptr;
    assign sda_oe_o    = q.oe;
    assign busy_o      = busy;

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
    parameter int WR_CYCLES = 64,
    parameter int PG_W      = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_i,
    input logic            sda_oe_o,
    input logic            busy_o,
    input logic            stop_det,
    input logic            in_wr_phase,
    input logic [PG_W-1:0] ptr_hi
);

    int unsigned bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bcnt_q <= 0;
        else if (busy_o) bcnt_q <= bcnt_q + 1;
        else             bcnt_q <= 0;
    end

    p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (bcnt_q < WR_CYCLES));

    p_launch_at_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_det));

    p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr_phase && $past(in_wr_phase)) |-> (ptr_hi == $past(ptr_hi)));

    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(
    .WR_CYCLES (WR_CYCLES),
    .PG_W      (PG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .busy_o      (busy_o),
    .stop_det    (stop_det),
    .in_wr_phase (in_wr_phase),
    .ptr_hi      (ptr_hi)
);

// File: tb/test_i2c_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_mem_slave;

    localparam int WR = 600;
    localparam int Q  = 6;
    localparam logic [7:0] SEL_W = 8'hAA;   // 1010, chip_en 101, write
    localparam logic [7:0] SEL_R = 8'hAB;   // same, read

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] ce = 3'b101;
    logic       sda_oe, busy, wr_ok, sda_line;
    logic [7:0] wp_addr;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign wr_ok    = (wp_addr[7:4] != 4'hC);

    i2c_mem_slave #(.WR_CYCLES(WR)) i_i2c_mem_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .chip_en_i (ce),
        .wr_ok_i   (wr_ok),
        .wp_addr_o (wp_addr),
        .sda_oe_o  (sda_oe),
        .busy_o    (busy)
    );

    int  errs = 0, checks = 0;
    int  mem_m [256];
    int  ptr_m = 0;
    int  run = 0, last_run = 0, runs = 0;
    bit  done = 0;

    // Busy-interval monitor, sampled every clock.
    always @(negedge clk) begin
        if (busy) run++;
        else begin
            if (run != 0) begin last_run = run; runs++; end
            run = 0;
        end
    end

    function automatic bit ok_m(input int a);
        return (a[7:4] != 4'hC);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic s);
        tick(Q); sda_m = b;
        tick(Q); scl = 1'b1;
        tick(Q); s = sda_line;
        tick(Q - 1);
        chk("R11 sda stable while scl high", sda_line, s);
        tick(1); scl = 1'b0;
    endtask

    task automatic start_c();
        tick(Q); sda_m = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); sda_m = 1'b0;
        tick(Q); scl = 1'b0;
    endtask

    task automatic stop_c();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
        bit_io(~mack, s);
    endtask

    task automatic poll(output int nacks);
        logic a;
        nacks = 0;
        for (int k = 0; k < 40; k++) begin
            start_c(); send_byte(SEL_W, a); stop_c();
            if (a) break;
            nacks++;
        end
    endtask

    task automatic do_write(input int base, input int dq[$], input string tag);
        logic a; bit ok = 1; int stg [16]; bit hit [16]; int nk; int r0;
        for (int i = 0; i < 16; i++) hit[i] = 0;
        start_c();
        send_byte(SEL_W, a);        chk("R2 select ack", a, 1);
        send_byte(8'(base), a);     chk("R3 address ack", a, 1);
        for (int i = 0; i < dq.size(); i++) begin
            int ad = (base & 'hF0) | ((base + i) & 'hF);
            send_byte(8'(dq[i]), a);
            if (ok) begin
                chk(ok_m(ad) ? tag : "R9 inhibited data nack", a, ok_m(ad));
                if (!ok_m(ad)) ok = 0;
                else begin stg[ad & 'hF] = dq[i]; hit[ad & 'hF] = 1; end
            end
        end
        r0 = runs;
        stop_c();
        if (ok && dq.size() > 0) begin
            for (int i = 0; i < 16; i++)
                if (hit[i]) mem_m[(base & 'hF0) | i] = stg[i];
            ptr_m = (base & 'hF0) | ((base + dq.size()) & 'hF);
            chk("R8 busy after stop", busy, 1);
            poll(nk);
            chk("R8 nack while busy", (nk > 0), 1);
            chk("R8 busy length", last_run, WR);
            chk("R8 one write cycle", runs - r0, 1);
        end else begin
            tick(8);
            chk("R9 no write cycle", busy, 0);
            chk("R9 no busy interval", runs - r0, 0);
        end
    endtask

    task automatic do_read(input int addr, input bit rnd, input int n, input string tag);
        logic a; logic [7:0] b;
        start_c();
        if (rnd) begin
            send_byte(SEL_W, a);    chk("R3 select ack", a, 1);
            send_byte(8'(addr), a); chk("R3 address ack", a, 1);
            ptr_m = addr;
            start_c();
        end
        send_byte(SEL_R, a);        chk("R2 read select ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(tag, b, mem_m[ptr_m]);
            ptr_m = (ptr_m + 1) & 'hFF;
        end
        stop_c();
    endtask

    initial begin
        logic a; logic [7:0] b; logic s; int q18[$];
        for (int i = 0; i < 256; i++) mem_m[i] = 0;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        chk("R1 sda released", sda_oe, 0);
        chk("R1 not busy", busy, 0);

        // R3: byte write then random read
        do_write('h23, '{'h5A}, "R3 data ack");
        do_read('h23, 1, 1, "R3 read back");

        // R2: select mismatches and chip enable
        start_c();
        send_byte(8'hA0, a); chk("R2 wrong chip enable nack", a, 0);
        send_byte(8'h23, a); chk("R2 ignored after mismatch", a, 0);
        stop_c();
        start_c();
        send_byte(8'h6A, a); chk("R2 wrong type code nack", a, 0);
        stop_c();
        ce = 3'b000;
        start_c();
        send_byte(8'hA0, a); chk("R2 matching strap ack", a, 1);
        stop_c();
        ce = 3'b101;
        tick(4);
        chk("R2 select-only write no busy", busy, 0);

        // R4/R6: page writes with wrap, then sequential and current reads
        do_write('h40, '{'h77, 'hC3}, "R4 data ack");
        for (int i = 0; i < 18; i++) q18.push_back('h80 + i);
        do_write('h3D, q18, "R4 page data ack");
        chk("R4 wrapped overwrite model", mem_m['h3D], 'h90);
        do_read('h30, 1, 17, "R4 page contents");
        do_read(0, 0, 1, "R6 current address");

        // R5: wrap FFh to 00h
        do_write('hFF, '{'h11}, "R5 data ack");
        do_write('h00, '{'h22}, "R5 data ack");
        do_read('hFE, 1, 3, "R5 sequential wrap");

        // R7: repeated Start discards pending data
        start_c();
        send_byte(SEL_W, a); chk("R7 select ack", a, 1);
        send_byte(8'h23, a); chk("R7 address ack", a, 1);
        send_byte(8'h99, a); chk("R7 data ack", a, 1);
        ptr_m = 'h24;
        do_read('h23, 1, 1, "R7 old data kept");
        tick(4);
        chk("R7 no write cycle", busy, 0);

        // R9: write-inhibited page
        do_write('hC4, '{'h33}, "R9");
        do_read('hC4, 1, 1, "R9 location unchanged");

        // R10: master NoAck then extra clocks, slave stays silent
        start_c();
        send_byte(SEL_W, a);
        send_byte(8'h23, a);
        start_c();
        send_byte(SEL_R, a);
        recv_byte(1'b0, b);  chk("R10 byte before nack", b, 'h5A);
        for (int i = 0; i < 9; i++) begin
            bit_io(1'b1, s);
            chk("R10 sda released after nack", s, 1);
        end
        stop_c();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
            $finish;
        end
    end

endmodule